// File: doc/BRIEF.md
# Read-to-Set Hardware Semaphore

This block is a single word-wide mutual-exclusion register that several bus masters share. A master claims a shared resource by reading the register. If the read finds the lock free, the master gets zero back and now owns the lock. The register then reads as all ones to everyone until it is released. A master that reads all ones does not own the lock, and it keeps polling. The owner releases the lock by writing any value that has at least one bit set, and that write returns the whole word to zero.

Two independent register ports reach the lock: an internal bus port and an external master port. Each port has a read strobe, a write strobe and write data. Each port returns its read data together with a valid pulse one cycle after the strobe. If both ports read a free lock in the same cycle, the internal port wins. The lock state is taken at the cycle the read is accepted, so two grants can never overlap. Ownership is advisory only: the block does not police accesses to the protected resource.

Top module: `hw_sem_top`

## Requirements
- R1: After reset the lock is free (the register value is 0x00000000) and both read-valid outputs are low.
- R2: A read that finds the lock free returns 0x00000000 on that port, with its read-valid high, in the cycle after the strobe.
- R3: After a granting read, the register holds 0xFFFFFFFF from the next clock edge on, so any later read returns 0xFFFFFFFF.
- R4: A read while the lock is held returns 0xFFFFFFFF and leaves the lock held.
- R5: A write whose data has any bit set, for example only bit 0 or only bit 31, clears the whole register to 0x00000000.
- R6: A write of 0x00000000 leaves the lock state unchanged.
- R7: When both ports read a free lock in the same cycle, only the internal port receives 0x00000000, and the external port receives 0xFFFFFFFF.
- R8: When a clearing write and a read fall in the same cycle, the write takes effect first, and the read is granted (it returns 0x00000000 and the lock ends up held).
- R9: Each read-valid output is high for exactly one cycle, one cycle after each read strobe, and is low otherwise.
- R10: Either port can take the lock, and either port can release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| int_rd | input | 1 | Internal port read strobe |
| int_wr | input | 1 | Internal port write strobe |
| int_wdata | input | 32 | Internal port write data |
| int_rvalid | output | 1 | Internal port read data valid, one cycle after the strobe |
| int_rdata | output | 32 | Internal port read data |
| ext_rd | input | 1 | External port read strobe |
| ext_wr | input | 1 | External port write strobe |
| ext_wdata | input | 32 | External port write data |
| ext_rvalid | output | 1 | External port read data valid, one cycle after the strobe |
| ext_rdata | output | 32 | External port read data |

## Verification
The assertions assume that the strobes are single-cycle and synchronous to the clock. They also assume that the strobes stay low while reset is applied or being released. They do not assume that only the owner writes, so a clear from a non-owner is legal stimulus. The bench drives its inputs on the falling edge and holds them low through reset. Its random phase mixes reads and writes on both ports, often in the same cycle. It weights write data toward zero, so that writes with no effect and clearing writes are both exercised.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned SEM_PORTS = 2;
  typedef enum logic [0:0] {
    PORT_INTERNAL = 1'b0,
    PORT_EXTERNAL = 1'b1
  } sem_port_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sem_port_req.sv
module sem_port_req #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_req,
  output logic              clr_req
);
  always_comb begin
    rd_req  = rd;
    clr_req = wr & (|wdata);
  end
endmodule

// File: rtl/sem_grant_arb.sv
module sem_grant_arb #(
  parameter int unsigned NP = 2
) (
  input  logic [NP-1:0] rd_req,
  input  logic          lock_free,
  output logic [NP-1:0] gnt
);
  logic [NP:0] seen;

  assign seen[0] = 1'b0;

  for (genvar p = 0; p < NP; p++) begin : g_pri
    assign gnt[p]    = rd_req[p] & lock_free & ~seen[p];
    assign seen[p+1] = seen[p] | rd_req[p];
  end
endmodule

// File: rtl/sem_lock_core.sv
module sem_lock_core (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_any,
  input  logic gnt_any,
  output logic lock_free,
  output logic lock_q
);
  logic lock_d;
  logic lock_en;
  logic held_after_clr;

  always_comb begin
    held_after_clr = lock_q & ~clr_any;
    lock_free      = ~held_after_clr;
    lock_en        = clr_any | gnt_any;
    lock_d         = held_after_clr | gnt_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end
endmodule

// File: rtl/sem_rsp_reg.sv
module sem_rsp_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              gnt,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = gnt ? '0 : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= rdata_d;
  end
endmodule

// File: rtl/hw_sem_top.sv
module hw_sem_top #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_rd,
  input  logic              int_wr,
  input  logic [DATA_W-1:0] int_wdata,
  output logic              int_rvalid,
  output logic [DATA_W-1:0] int_rdata,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic              ext_rvalid,
  output logic [DATA_W-1:0] ext_rdata
);
  import sem_pkg::*;
  localparam int unsigned NP = SEM_PORTS;

  logic              rst_n_sync;
  logic [NP-1:0]     rd_v;
  logic [NP-1:0]     wr_v;
  logic [DATA_W-1:0] wd_a [NP];
  logic [NP-1:0]     rd_req_v;
  logic [NP-1:0]     clr_v;
  logic [NP-1:0]     gnt_v;
  logic [NP-1:0]     rv_v;
  logic [DATA_W-1:0] rdat_a [NP];
  logic              lock_free;
  logic              lock_q;

  assign rd_v[PORT_INTERNAL] = int_rd;
  assign rd_v[PORT_EXTERNAL] = ext_rd;
  assign wr_v[PORT_INTERNAL] = int_wr;
  assign wr_v[PORT_EXTERNAL] = ext_wr;
  assign wd_a[PORT_INTERNAL] = int_wdata;
  assign wd_a[PORT_EXTERNAL] = ext_wdata;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    sem_port_req #(.DATA_W(DATA_W)) u_req (
      .rd(rd_v[p]), .wr(wr_v[p]), .wdata(wd_a[p]),
      .rd_req(rd_req_v[p]), .clr_req(clr_v[p])
    );
    sem_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
      .clk(clk), .rst_n(rst_n_sync), .rd_req(rd_req_v[p]), .gnt(gnt_v[p]),
      .rvalid(rv_v[p]), .rdata(rdat_a[p])
    );
  end

  sem_grant_arb #(.NP(NP)) u_arb (
    .rd_req(rd_req_v), .lock_free(lock_free), .gnt(gnt_v)
  );

  sem_lock_core u_core (
    .clk(clk), .rst_n(rst_n_sync), .clr_any(|clr_v), .gnt_any(|gnt_v),
    .lock_free(lock_free), .lock_q(lock_q)
  );

  assign int_rvalid = rv_v[PORT_INTERNAL];
  assign int_rdata  = rdat_a[PORT_INTERNAL];
  assign ext_rvalid = rv_v[PORT_EXTERNAL];
  assign ext_rdata  = rdat_a[PORT_EXTERNAL];
endmodule

// File: rtl/hw_sem_chk.sv
module hw_sem_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              int_rd,
  input logic              int_wr,
  input logic [DATA_W-1:0] int_wdata,
  input logic              int_rvalid,
  input logic [DATA_W-1:0] int_rdata,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              ext_rvalid,
  input logic [DATA_W-1:0] ext_rdata,
  input logic              lock_q
);
  logic any_clr, any_rd, int_won, ext_won;
  assign any_clr = (int_wr && (int_wdata != '0)) || (ext_wr && (ext_wdata != '0));
  assign any_rd  = int_rd || ext_rd;
  assign int_won = int_rvalid && (int_rdata == '0);
  assign ext_won = ext_rvalid && (ext_rdata == '0);

  AST_GRANT_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (int_won || ext_won) |-> ($past(!lock_q) || $past(any_clr))); // R2
  AST_HELD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (int_won || ext_won) |-> lock_q); // R3
  AST_HELD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(int_rd) && $past(lock_q) && !$past(any_clr)) |-> (int_rdata == '1 && lock_q)); // R4
  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(any_clr) && !$past(any_rd)) |-> !lock_q); // R5
  AST_ZERO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!any_clr && !any_rd) |=> $stable(lock_q)); // R6
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(int_won && ext_won)); // R7
  AST_CLEAR_THEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (any_clr && int_rd) |=> int_won); // R8
  AST_INT_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n_sync)
    int_rvalid == $past(int_rd)); // R9
  AST_EXT_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ext_rvalid == $past(ext_rd)); // R9
endmodule

bind hw_sem_top hw_sem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync),
  .int_rd(int_rd), .int_wr(int_wr), .int_wdata(int_wdata),
  .int_rvalid(int_rvalid), .int_rdata(int_rdata),
  .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
  .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata),
  .lock_q(lock_q)
);

// File: tb/hw_sem_top_tb.sv
module hw_sem_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_rd = 1'b0, int_wr = 1'b0, ext_rd = 1'b0, ext_wr = 1'b0;
  logic [31:0] int_wdata = '0, ext_wdata = '0;
  logic        int_rvalid, ext_rvalid;
  logic [31:0] int_rdata, ext_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit lk = 0;
  bit exp_iv, exp_ev;
  logic [31:0] exp_id, exp_ed;

  always #10 clk = ~clk;

  hw_sem_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .int_rd(int_rd), .int_wr(int_wr), .int_wdata(int_wdata),
    .int_rvalid(int_rvalid), .int_rdata(int_rdata),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle on both ports: drive at falling edge, model, check at next falling edge.
  task automatic step(input bit ir, input bit iw, input logic [31:0] iwd,
                      input bit er, input bit ew, input logic [31:0] ewd,
                      input string tag);
    int_rd = ir; int_wr = iw; int_wdata = iwd;
    ext_rd = er; ext_wr = ew; ext_wdata = ewd;
    if ((iw && iwd != 0) || (ew && ewd != 0)) lk = 0;
    exp_iv = ir;
    exp_ev = er;
    if (ir) begin exp_id = lk ? 32'hFFFF_FFFF : 32'h0; lk = 1; end
    if (er) begin exp_ed = lk ? 32'hFFFF_FFFF : 32'h0; lk = 1; end
    @(negedge clk);
    int_rd = 0; int_wr = 0; ext_rd = 0; ext_wr = 0;
    check(tag, "int_rvalid", {31'b0, int_rvalid}, {31'b0, exp_iv});
    check(tag, "ext_rvalid", {31'b0, ext_rvalid}, {31'b0, exp_ev});
    if (exp_iv) check(tag, "int_rdata", int_rdata, exp_id);
    if (exp_ev) check(tag, "ext_rdata", ext_rdata, exp_ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "int_rvalid in reset", {31'b0, int_rvalid}, 32'h0);
    check("R1", "ext_rvalid in reset", {31'b0, ext_rvalid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(0,0,0, 0,0,0, "R1");
    step(1,0,0, 0,0,0, "R2");                     // free -> internal gets zero
    step(0,0,0, 1,0,0, "R3");                     // now reads ones
    step(1,0,0, 0,0,0, "R4");                     // held stays held
    step(0,0,0, 0,0,0, "R9");
    step(0,1,32'h0, 0,0,0, "R6");                 // zero write: no effect
    step(0,0,0, 1,0,0, "R6");
    step(0,0,0, 0,1,32'h8000_0000, "R5");         // bit 31 alone clears
    step(0,0,0, 1,0,0, "R10");                    // external takes the lock
    step(1,0,0, 0,0,0, "R4");
    step(0,1,32'h0000_0001, 0,0,0, "R5");         // bit 0 alone clears (from internal)
    step(1,0,0, 1,0,0, "R7");                     // simultaneous: internal wins
    step(0,0,0, 1,1,32'h0000_0010, "R8");         // clear and read same cycle
    step(1,0,0, 0,0,0, "R8");
    step(0,0,0, 0,1,32'h1, "R10");                // external releases
    step(0,0,0, 1,0,0, "R10");
    step(1,1,32'h4, 0,0,0, "R8");                 // same-port clear plus read
    step(0,0,0, 0,0,0, "R9");
    for (int i = 0; i < 600; i++) begin
      bit ir, iw, er, ew;
      logic [31:0] iwd, ewd;
      ir = ($urandom % 3) == 0;
      er = ($urandom % 3) == 0;
      iw = ($urandom % 4) == 0;
      ew = ($urandom % 4) == 0;
      iwd = ($urandom % 2) ? 32'h0 : (32'h1 << ($urandom % 32));
      ewd = ($urandom % 2) ? 32'h0 : $urandom;
      step(ir, iw, iwd, er, ew, ewd, "R9");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule